// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Leg Modulator

This block drives one phase leg of a five-level inverter built from two H-bridge cells connected in series. On every clock it compares a signed reference sample, supplied by an external sine source and already scaled by the modulation index, with four triangular carriers stacked one above another. All four carriers come from a single shared up/down counter. The number of carriers that the reference exceeds gives an output level from -2 to +2. That level is split across the two cells, and each cell state is decoded into the four switch gates of its bridge.

A disposition input chooses how the carriers relate to each other. In the first setting all four carriers rise and fall together. In the second, the two carriers above zero run inverted against the two below zero. A divider input sets how many clocks each counter step takes, and this sets the carrier period. The enable input starts and stops modulation. Dead-time insertion happens after this block.

Top module: `lvl_spwm_leg`

## Requirements
- R1: The carrier counter runs from 0 up to 511 and back down to 0, reversing at each end, so that one carrier period is 1022 steps. It advances one step every `period_div_i`+1 clocks. Carrier k (k = 0..3) has the base value (k-2)*512, which gives -1024, -512, 0 and +512, so the four carriers together cover -1024..1023.
- R2: The output level is the number of carriers for which the latched reference is strictly greater than the carrier, minus two. The level is signed 3-bit and always lies in -2..+2.
- R3: With `mode_i`=0, every carrier equals its base plus the counter value.
- R4: With `mode_i`=1, carriers 2 and 3 (the two above zero) equal their base plus 511 minus the counter value. Carriers 0 and 1 keep the same form as in R3.
- R5: Level-to-cell mapping: +2 sets both cells to +1. +1 sets cell 1 to +1 and cell 2 to 0. 0 sets both cells to 0. -1 sets cell 1 to -1 and cell 2 to 0. -2 sets both cells to -1.
- R6: Each cell drives four gates in the bit order {leg B lower, leg B upper, leg A lower, leg A upper}. A cell at +1 outputs 4'b1001, a cell at 0 outputs 4'b1010 (both lower switches on), and a cell at -1 outputs 4'b0110. Cell 1 sits in `gate_o[3:0]` and cell 2 in `gate_o[7:4]`. The upper and lower gates of one leg are never high together.
- R7: The reference is captured when modulation starts and again at each carrier peak, which is the step on which the counter turns from 511 back to 510. A change on `ref_i` at any other time has no effect on the outputs until the next peak.
- R8: When `en_i` is low at a clock edge, `gate_o` and `level_o` are 0 after that edge. While `en_i` stays low, `ref_i` has no effect.
- R9: The first edge with `en_i` high after a disabled period restarts the counter at 0 in the upward direction and keeps the outputs at 0. The next edge presents the level for counter value 0.
- R10: `gate_o` and `level_o` are registered. Each value reflects the counter and the latched reference as they stood after the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Modulation enable |
| mode_i | input | 1 | Carrier disposition: 0 in phase, 1 upper pair inverted |
| period_div_i | input | 8 | Clocks per counter step, minus one |
| ref_i | input | 12 | Signed reference sample |
| level_o | output | 3 | Signed output level, -2..+2 |
| gate_o | output | 8 | Switch gates of cell 2 (bits 7:4) and cell 1 (bits 3:0) |

## Verification
The reference is held at fixed values spread across the range. Zero and the two extreme values must give a constant level. A value of +1023 drops to +1 only at the top of the counter, which exposes an off-by-one in the strict comparison. A value of +256 is run in both modes: the time when the level changes moves from the rising half of the carrier to the falling half, which confirms that the upper carriers are inverted. A value of -256 gives the same pattern in both modes, which confirms that the lower carriers are left alone. A slower divider stretches every edge by the expected factor. A reference step in the middle of a ramp must not show up until the next peak. A disable in the middle of a period, with the reference moving while disabled, must force the gates low and then restart the counter from zero.

// File: rtl/lvl_spwm_pkg.sv
package lvl_spwm_pkg;

    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_RISE = 2'd1,
        CG_FALL = 2'd2
    } cg_state_e;

    typedef enum logic {
        DISP_IN_PHASE = 1'b0,
        DISP_OPPOSED  = 1'b1
    } disp_e;

    typedef logic signed [1:0] cell_t;

    localparam int NUM_CARRIERS   = 4;
    localparam int NUM_CELLS      = 2;
    localparam int GATES_PER_CELL = 4;
    localparam int LVL_W          = 3;

    localparam cell_t CELL_POS  = 2'sb01;
    localparam cell_t CELL_ZERO = 2'sb00;
    localparam cell_t CELL_NEG  = 2'sb11;

    // gate bit order per cell: {b_lo, b_hi, a_lo, a_hi}
    localparam logic [GATES_PER_CELL-1:0] GATE_POS  = 4'b1001;
    localparam logic [GATES_PER_CELL-1:0] GATE_ZERO = 4'b1010;
    localparam logic [GATES_PER_CELL-1:0] GATE_NEG  = 4'b0110;

endpackage

// File: rtl/lvl_carrier_gen.sv
module lvl_carrier_gen
    import lvl_spwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 9,
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [DIV_W-1:0]        div_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic signed [REF_W-1:0] ref_q_o,
    output logic                    run_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_BOT = '0;

    cg_state_e               state_q, state_d;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic [DIV_W-1:0]        presc_q, presc_d;
    logic signed [REF_W-1:0] ref_q, ref_d;
    logic                    tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CG_IDLE;
            cnt_q   <= '0;
            presc_q <= '0;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            presc_q <= presc_d;
            ref_q   <= ref_d;
        end
    end

    // next state: IDLE -start-> RISE -peak-> FALL -valley-> RISE, any -stop-> IDLE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        presc_d = presc_q;
        ref_d   = ref_q;
        tick    = (presc_q >= div_i);
        unique case (state_q)
            CG_IDLE: begin
                cnt_d   = CNT_BOT;
                presc_d = '0;
                if (en_i) begin
                    state_d = CG_RISE;
                    ref_d   = ref_i;
                end
            end
            CG_RISE: begin
                if (!en_i) begin
                    state_d = CG_IDLE;
                    cnt_d   = CNT_BOT;
                    presc_d = '0;
                end else if (tick) begin
                    presc_d = '0;
                    if (cnt_q == CNT_TOP) begin
                        state_d = CG_FALL;
                        cnt_d   = CNT_TOP - 1'b1;
                        ref_d   = ref_i;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    presc_d = presc_q + 1'b1;
                end
            end
            CG_FALL: begin
                if (!en_i) begin
                    state_d = CG_IDLE;
                    cnt_d   = CNT_BOT;
                    presc_d = '0;
                end else if (tick) begin
                    presc_d = '0;
                    if (cnt_q == CNT_BOT) begin
                        state_d = CG_RISE;
                        cnt_d   = CNT_BOT + 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end else begin
                    presc_d = presc_q + 1'b1;
                end
            end
            default: begin
                state_d = CG_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt_o   = cnt_q;
        ref_q_o = ref_q;
        run_o   = (state_q != CG_IDLE);
    end

endmodule

// File: rtl/lvl_level_sel.sv
module lvl_level_sel
    import lvl_spwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 9
) (
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic                    mode_i,
    output logic signed [LVL_W-1:0] level_o
);

    localparam int CW   = REF_W + 1;
    localparam int BAND = 1 << CNT_W;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [NUM_CARRIERS-1:0] above;
    logic signed [CW-1:0]    ref_x;
    logic [LVL_W-1:0]        hits;

    assign ref_x = {ref_i[REF_W-1], ref_i};

    for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_car
        localparam logic signed [CW-1:0] BASE = CW'((k - NUM_CARRIERS / 2) * BAND);
        logic [CNT_W-1:0]     pos;
        logic signed [CW-1:0] carrier;
        if (k >= NUM_CARRIERS / 2) begin : g_upper
            assign pos = (disp_e'(mode_i) == DISP_OPPOSED) ? (CNT_TOP - cnt_i) : cnt_i;
        end else begin : g_lower
            assign pos = cnt_i;
        end
        assign carrier  = BASE + $signed({{(CW - CNT_W){1'b0}}, pos});
        assign above[k] = (ref_x > carrier);
    end

    always_comb begin
        hits = '0;
        for (int k = 0; k < NUM_CARRIERS; k++) begin
            hits = hits + LVL_W'(above[k]);
        end
        level_o = $signed(hits - LVL_W'(NUM_CARRIERS / 2));
    end

endmodule

// File: rtl/lvl_cell_map.sv
module lvl_cell_map
    import lvl_spwm_pkg::*;
(
    input  logic signed [LVL_W-1:0] level_i,
    output cell_t                   cell1_o,
    output cell_t                   cell2_o
);

    always_comb begin
        case (level_i)
            3'sd2: begin
                cell1_o = CELL_POS;
                cell2_o = CELL_POS;
            end
            3'sd1: begin
                cell1_o = CELL_POS;
                cell2_o = CELL_ZERO;
            end
            -3'sd1: begin
                cell1_o = CELL_NEG;
                cell2_o = CELL_ZERO;
            end
            -3'sd2: begin
                cell1_o = CELL_NEG;
                cell2_o = CELL_NEG;
            end
            default: begin
                cell1_o = CELL_ZERO;
                cell2_o = CELL_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/lvl_gate_dec.sv
module lvl_gate_dec
    import lvl_spwm_pkg::*;
#(
    parameter int NCELL = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_i,
    input  logic signed [LVL_W-1:0]       level_i,
    input  logic [2*NCELL-1:0]            cells_i,
    output logic [GATES_PER_CELL*NCELL-1:0] gate_o,
    output logic signed [LVL_W-1:0]       level_o
);

    localparam int GW = GATES_PER_CELL * NCELL;

    logic [GW-1:0] dec;

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        always_comb begin
            case (cells_i[2*c +: 2])
                CELL_POS: dec[GATES_PER_CELL*c +: GATES_PER_CELL] = GATE_POS;
                CELL_NEG: dec[GATES_PER_CELL*c +: GATES_PER_CELL] = GATE_NEG;
                default:  dec[GATES_PER_CELL*c +: GATES_PER_CELL] = GATE_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_o  <= '0;
            level_o <= '0;
        end else if (run_i) begin
            gate_o  <= dec;
            level_o <= level_i;
        end else begin
            gate_o  <= '0;
            level_o <= '0;
        end
    end

endmodule

// File: rtl/lvl_spwm_leg.sv
module lvl_spwm_leg
    import lvl_spwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    mode_i,
    input  logic [DIV_W-1:0]        period_div_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic signed [2:0]       level_o,
    output logic [7:0]              gate_o
);

    localparam int CNT_W = REF_W - 3;

    logic [CNT_W-1:0]        cnt_w;
    logic signed [REF_W-1:0] ref_q_w;
    logic                    run_w;
    logic signed [LVL_W-1:0] level_w;
    cell_t                   cell1_w, cell2_w;

    lvl_carrier_gen #(
        .REF_W (REF_W),
        .CNT_W (CNT_W),
        .DIV_W (DIV_W)
    ) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .div_i   (period_div_i),
        .ref_i   (ref_i),
        .cnt_o   (cnt_w),
        .ref_q_o (ref_q_w),
        .run_o   (run_w)
    );

    lvl_level_sel #(
        .REF_W (REF_W),
        .CNT_W (CNT_W)
    ) u_sel (
        .ref_i   (ref_q_w),
        .cnt_i   (cnt_w),
        .mode_i  (mode_i),
        .level_o (level_w)
    );

    lvl_cell_map u_map (
        .level_i (level_w),
        .cell1_o (cell1_w),
        .cell2_o (cell2_w)
    );

    lvl_gate_dec #(
        .NCELL (NUM_CELLS)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (en_i && run_w),
        .level_i (level_w),
        .cells_i ({cell2_w, cell1_w}),
        .gate_o  (gate_o),
        .level_o (level_o)
    );

endmodule

// File: rtl/lvl_spwm_chk.sv
module lvl_spwm_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic signed [2:0] level_o,
    input logic [7:0]        gate_o
);

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_o & (gate_o >> 1)) & 8'h55) == 8'h00); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (gate_o == 8'h00 && level_o == 3'sd0)); // R8

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o >= -3'sd2) && (level_o <= 3'sd2)); // R2

    AST_ZERO_LOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != 8'h00 && level_o == 3'sd0) |-> gate_o == 8'hAA); // R5

    AST_POS_CELL1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != 8'h00 && level_o > 3'sd0) |-> gate_o[3:0] == 4'b1001); // R5

    AST_NEG_CELL1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != 8'h00 && level_o < 3'sd0) |-> gate_o[3:0] == 4'b0110); // R5

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |=> gate_o == 8'h00); // R9

endmodule

bind lvl_spwm_leg lvl_spwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .level_o (level_o),
    .gate_o  (gate_o)
);

// File: tb/tb_lvl_spwm_leg.sv
`timescale 1ns/1ps
module tb_lvl_spwm_leg;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_i = 1'b0;
    logic              mode_i = 1'b0;
    logic [7:0]        period_div_i = 8'd0;
    logic signed [11:0] ref_i = '0;
    logic signed [2:0] level_o;
    logic [7:0]        gate_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lvl_spwm_leg dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .mode_i       (mode_i),
        .period_div_i (period_div_i),
        .ref_i        (ref_i),
        .level_o      (level_o),
        .gate_o       (gate_o)
    );

    task automatic check(string tag, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // R1: triangle 0..511..0
    function automatic int tri_pos(int t);
        int r;
        r = t % 1022;
        return (r <= 511) ? r : 1022 - r;
    endfunction

    // R2, R3, R4
    function automatic int exp_level(int rv, int md, int cnt);
        int hits;
        hits = 0;
        for (int k = 0; k < 4; k++) begin
            int car;
            car = (k - 2) * 512 + ((md == 1 && k >= 2) ? (511 - cnt) : cnt);
            if (rv > car) hits++;
        end
        return hits - 2;
    endfunction

    // R5, R6
    function automatic int cell_code(int s);
        return (s > 0) ? 9 : ((s < 0) ? 6 : 10);
    endfunction

    function automatic int exp_gate(int lvl);
        int c1, c2;
        c1 = (lvl > 0) ? 1 : ((lvl < 0) ? -1 : 0);
        c2 = (lvl == 2) ? 1 : ((lvl == -2) ? -1 : 0);
        return cell_code(c2) * 16 + cell_code(c1);
    endfunction

    task automatic run_seq(string tag, int ref_a, int ref_b, int switch_at,
                           int md, int dv_set, int n);
        int refq, dv, j, cnt, lvl;
        dv = dv_set + 1;
        refq = 0;
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check(tag, int'(gate_o), 0, "gates while disabled (R8)");
        ref_i = 12'(ref_a);
        mode_i = md[0];
        period_div_i = 8'(dv_set);
        en_i = 1'b1;
        for (int m = 0; m <= n; m++) begin
            @(negedge clk);
            if (m == 0) begin
                check(tag, int'(gate_o), 0, "gates on enable edge (R9)");
                check(tag, int'(level_o), 0, "level on enable edge (R9)");
            end else begin
                j = m - 1;
                if (j == 0 || (j % dv == 0 && ((j / dv) % 1022) == 512))
                    refq = (j > switch_at) ? ref_b : ref_a; // R7
                cnt = tri_pos(j / dv);
                lvl = exp_level(refq, md, cnt);
                check(tag, int'(level_o), lvl, "level (R10)");
                check(tag, int'(gate_o), exp_gate(lvl), "gates (R6)");
            end
            if (m == switch_at) ref_i = 12'(ref_b);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", int'(gate_o), 0, "gates in reset");
        check("R2", int'(level_o), 0, "level in reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_disable();
        @(negedge clk);
        en_i = 1'b0;
        ref_i = 12'sd2047;
        @(negedge clk);
        check("R8", int'(gate_o), 0, "gates after disable");
        check("R8", int'(level_o), 0, "level after disable");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ref_i = (i % 2 == 0) ? -12'sd2048 : 12'sd900;
            check("R8", int'(gate_o), 0, "gates held low");
        end
    endtask

    initial begin
        t_reset();
        run_seq("R2", 0, 0, 1 << 30, 0, 0, 1100);
        run_seq("R2", 1023, 1023, 1 << 30, 0, 0, 1100);
        run_seq("R3", 256, 256, 1 << 30, 0, 0, 800);
        run_seq("R4", 256, 256, 1 << 30, 1, 0, 800);
        run_seq("R4", -256, -256, 1 << 30, 1, 0, 800);
        run_seq("R3", -256, -256, 1 << 30, 0, 0, 800);
        run_seq("R5", -2048, -2048, 1 << 30, 0, 0, 300);
        run_seq("R5", 2047, 2047, 1 << 30, 1, 0, 300);
        run_seq("R1", 700, 700, 1 << 30, 0, 3, 4200);
        run_seq("R7", 0, 2047, 300, 0, 0, 1700);
        run_seq("R7", -700, 100, 900, 1, 1, 2300);
        run_seq("R6", 600, 600, 700, 0, 0, 700);
        t_disable();
        run_seq("R9", 256, 256, 1 << 30, 0, 0, 600);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule